// File: doc/BRIEF.md
# Queue Setup Sequencer with Daisy-Chained Completion

This block configures one device of a multi-queue buffer when the device comes out of master reset. While the master reset input is high it captures a few strap pins: a default-enable pin, a three-bit queue-select code, an offset-select pin and a bus-width code. From these it decides which setup mode the device uses. Serial mode is recognised but never loaded. Default mode gives every queue an equal share of memory, using the largest queue count. Parallel mode takes a queue-count exponent from the write or read address bus on the first clock after reset.

After master reset falls, a load counter runs for a fixed number of write-clock cycles. At its last cycle the queue count, the per-queue depth, the almost-empty/almost-full offset and the bus-width mode are written to output registers. They then stay fixed until the next master reset. Completion is signalled by a serial-enable output that goes from high to low. Devices are chained output to input, with the first device's input tied low. A device lowers its output only when its own load is finished and its upstream input is low. The last device's output therefore marks the whole chain as ready.

Top module: `queue_setup_seq`

## Requirements
- R1: While `mrst_i` is high, and from `rst_ni` low, `chain_out_o` is high from the next clock edge onward. The committed setup outputs read zero after any edge that sees `mrst_i` high.
- R2: At each edge with `mrst_i` high, the mode is captured. `dflt_mode_i` low selects serial (`mode_o`=0). `dflt_mode_i` high with `qsel_i` equal to 3'b110 or 3'b111 selects parallel (2). Any other code selects default (1). `mode_o` holds the last captured value.
- R3: The setup outputs stay zero until the LOAD_CYCLES-th rising edge after `mrst_i` is sampled low. They take their new values at that edge.
- R4: In default mode, `queue_count_o` = MAX_QUEUES and `depth_o` = MEM_WORDS / MAX_QUEUES.
- R5: In parallel mode, the exponent k is read from bits [KEY_W-1:0] of `wr_addr_i` (code 110) or `rd_addr_i` (code 111). It is sampled at the first edge after `mrst_i` falls. k is limited to log2(MAX_QUEUES). Then `queue_count_o` = 2^k and `depth_o` = MEM_WORDS >> k.
- R6: `ofs_o` is OFS_HI when `ofs_sel_i` was high at the last master-reset edge, and OFS_LO otherwise.
- R7: `bus_mode_o` is the `bm_i` value captured at the last master-reset edge.
- R8: If `chain_in_i` is low at the commit edge, `chain_out_o` falls at that same edge.
- R9: If `chain_in_i` is high at the commit edge, `chain_out_o` stays high. It falls at the first later edge that samples `chain_in_i` low.
- R10: After completion, changes on the strap pins, the address buses and `chain_in_i` leave every output unchanged until the next master reset.
- R11: In serial mode the setup outputs stay zero and `chain_out_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mrst_i | input | 1 | Master reset, active high, synchronous |
| dflt_mode_i | input | 1 | Default-enable strap, sampled in master reset |
| qsel_i | input | 3 | Queue-select code, sampled in master reset |
| ofs_sel_i | input | 1 | Offset-select strap, sampled in master reset |
| bm_i | input | BM_W | Bus-width strap, sampled in master reset |
| wr_addr_i | input | ADDR_W | Write address bus; carries the exponent for code 110 |
| rd_addr_i | input | ADDR_W | Read address bus; carries the exponent for code 111 |
| chain_in_i | input | 1 | Serial-enable from the upstream device |
| chain_out_o | output | 1 | Serial-enable to the downstream device; low when this device and all upstream devices are set up |
| mode_o | output | 2 | Captured setup mode |
| queue_count_o | output | log2(MAX_QUEUES)+1 | Number of queues |
| depth_o | output | log2(MEM_WORDS)+1 | Words per queue |
| ofs_o | output | OFS_W | Almost-empty/almost-full offset |
| bus_mode_o | output | BM_W | Bus-width mode |

## Verification
Every result comes from a register, so each one is due one edge after the stimulus that causes it. The captured mode is due one edge after master reset is seen high. The address exponent is taken at edge 1 after release, and the setup outputs change at edge LOAD_CYCLES. A held-off chain output falls at the first edge that samples the upstream input low. The bench drives inputs on falling edges and updates a behavioural model on each rising edge. It compares every output on every falling edge, so each result is checked half a cycle after the edge that produced it. Directed checks also look at edge LOAD_CYCLES-1 and edge LOAD_CYCLES, to pin down the exact commit cycle.

// File: rtl/qss_pkg.sv
package qss_pkg;
  typedef enum logic [1:0] {
    MODE_SERIAL   = 2'd0,
    MODE_DEFAULT  = 2'd1,
    MODE_PARALLEL = 2'd2
  } setup_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_WAIT,
    PH_DONE,
    PH_SERIAL
  } phase_e;

  localparam logic [2:0] QSEL_WR = 3'b110;
  localparam logic [2:0] QSEL_RD = 3'b111;

  function automatic setup_mode_e decode_mode(input logic dflt, input logic [2:0] qsel);
    if (!dflt) return MODE_SERIAL;
    if (qsel == QSEL_WR || qsel == QSEL_RD) return MODE_PARALLEL;
    return MODE_DEFAULT;
  endfunction
endpackage

// File: rtl/qss_pin_capture.sv
module qss_pin_capture
  import qss_pkg::*;
#(
  parameter int BM_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mrst_i,
  input  logic            dflt_mode_i,
  input  logic [2:0]      qsel_i,
  input  logic            ofs_sel_i,
  input  logic [BM_W-1:0] bm_i,
  output setup_mode_e     mode_o,
  output logic            use_rd_o,
  output logic            ofs_sel_o,
  output logic [BM_W-1:0] bm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= MODE_SERIAL;
      use_rd_o  <= 1'b0;
      ofs_sel_o <= 1'b0;
      bm_o      <= '0;
    end else if (mrst_i) begin
      mode_o    <= decode_mode(dflt_mode_i, qsel_i);
      use_rd_o  <= (qsel_i == QSEL_RD);
      ofs_sel_o <= ofs_sel_i;
      bm_o      <= bm_i;
    end
  end

  // straps only move during master reset
  p_straps_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrst_i |=> ($stable(mode_o) && $stable(ofs_sel_o) && $stable(bm_o)));
endmodule

// File: rtl/qss_load_timer.sv
module qss_load_timer #(
  parameter int LOAD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mrst_i,
  output logic first_o,
  output logic last_o
);
  localparam int CW = $clog2(LOAD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOAD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign first_o = active_q && !mrst_i && (cnt_q == '0);
  assign last_o  = active_q && !mrst_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (mrst_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == LAST) active_q <= 1'b0;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  // one commit per reset release
  p_single_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o);
endmodule

// File: rtl/qss_cfg_calc.sv
module qss_cfg_calc
  import qss_pkg::*;
#(
  parameter int MAX_QUEUES = 64,
  parameter int MEM_WORDS  = 16384,
  parameter int ADDR_W     = 8,
  parameter int KEY_W      = 3,
  parameter int OFS_W      = 8,
  parameter int OFS_LO     = 8,
  parameter int OFS_HI     = 128,
  parameter int BM_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  setup_mode_e       mode_i,
  input  logic              use_rd_i,
  input  logic              ofs_sel_i,
  input  logic [BM_W-1:0]   bm_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              first_i,
  input  logic              commit_i,
  output logic [$clog2(MAX_QUEUES):0] queue_count_o,
  output logic [$clog2(MEM_WORDS):0]  depth_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [BM_W-1:0]   bus_mode_o
);
  localparam int LOG_MAXQ = $clog2(MAX_QUEUES);
  localparam int QCW      = LOG_MAXQ + 1;
  localparam int DW       = $clog2(MEM_WORDS) + 1;

  logic [KEY_W-1:0] key_live, key_q, key_req;
  int unsigned      k_eff;
  logic [QCW-1:0]   count_n;
  logic [DW-1:0]    depth_n;

  assign key_live = use_rd_i ? rd_addr_i[KEY_W-1:0] : wr_addr_i[KEY_W-1:0];
  assign key_req  = first_i ? key_live : key_q;

  always_comb begin
    if (mode_i != MODE_PARALLEL)          k_eff = LOG_MAXQ;
    else if (int'(key_req) > LOG_MAXQ)    k_eff = LOG_MAXQ;
    else                                  k_eff = int'(key_req);
    count_n = QCW'(1) << k_eff;
    depth_n = DW'(MEM_WORDS) >> k_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      key_q <= '0;
    else if (first_i) key_q <= key_live;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      queue_count_o <= '0;
      depth_o       <= '0;
      ofs_o         <= '0;
      bus_mode_o    <= '0;
    end else if (mrst_i) begin
      queue_count_o <= '0;
      depth_o       <= '0;
      ofs_o         <= '0;
      bus_mode_o    <= '0;
    end else if (commit_i) begin
      queue_count_o <= count_n;
      depth_o       <= depth_n;
      ofs_o         <= ofs_sel_i ? OFS_W'(OFS_HI) : OFS_W'(OFS_LO);
      bus_mode_o    <= bm_i;
    end
  end

  p_mem_split_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !mrst_i) |=> (int'(queue_count_o) * int'(depth_o) == MEM_WORDS));

  p_count_pow2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (queue_count_o != '0) |-> $onehot(queue_count_o));
endmodule

// File: rtl/qss_chain_ctrl.sv
module qss_chain_ctrl
  import qss_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mrst_i,
  input  logic last_i,
  input  logic serial_i,
  input  logic chain_in_i,
  output logic chain_out_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      chain_out_o <= 1'b1;
    end else if (mrst_i) begin
      ph_q        <= PH_LOAD;
      chain_out_o <= 1'b1;
    end else begin
      unique case (ph_q)
        PH_LOAD: if (last_i) begin
          if (serial_i)         ph_q <= PH_SERIAL;
          else if (!chain_in_i) begin
            ph_q        <= PH_DONE;
            chain_out_o <= 1'b0;
          end else              ph_q <= PH_WAIT;
        end
        PH_WAIT: if (!chain_in_i) begin
          ph_q        <= PH_DONE;
          chain_out_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  p_high_in_mrst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> chain_out_o);

  p_fall_needs_upstream_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chain_out_o) |-> $past(!chain_in_i));

  p_hold_while_upstream_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WAIT && chain_in_i && !mrst_i) |=> chain_out_o);

  p_serial_never_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SERIAL) |-> chain_out_o);
endmodule

// File: rtl/queue_setup_seq.sv
module queue_setup_seq
  import qss_pkg::*;
#(
  parameter int LOAD_CYCLES = 16,
  parameter int MAX_QUEUES  = 64,
  parameter int MEM_WORDS   = 16384,
  parameter int ADDR_W      = 8,
  parameter int KEY_W       = 3,
  parameter int OFS_W       = 8,
  parameter int OFS_LO      = 8,
  parameter int OFS_HI      = 128,
  parameter int BM_W        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              dflt_mode_i,
  input  logic [2:0]        qsel_i,
  input  logic              ofs_sel_i,
  input  logic [BM_W-1:0]   bm_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              chain_in_i,
  output logic              chain_out_o,
  output logic [1:0]        mode_o,
  output logic [$clog2(MAX_QUEUES):0] queue_count_o,
  output logic [$clog2(MEM_WORDS):0]  depth_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [BM_W-1:0]   bus_mode_o
);
  setup_mode_e     mode;
  logic            use_rd, ofs_sel, first, last, commit;
  logic [BM_W-1:0] bm_cap;

  assign mode_o = mode;
  assign commit = last && (mode != MODE_SERIAL);

  qss_pin_capture #(.BM_W(BM_W)) u_cap (
    .clk_i, .rst_ni, .mrst_i, .dflt_mode_i, .qsel_i, .ofs_sel_i, .bm_i,
    .mode_o(mode), .use_rd_o(use_rd), .ofs_sel_o(ofs_sel), .bm_o(bm_cap)
  );

  qss_load_timer #(.LOAD_CYCLES(LOAD_CYCLES)) u_timer (
    .clk_i, .rst_ni, .mrst_i, .first_o(first), .last_o(last)
  );

  qss_cfg_calc #(
    .MAX_QUEUES(MAX_QUEUES), .MEM_WORDS(MEM_WORDS), .ADDR_W(ADDR_W), .KEY_W(KEY_W),
    .OFS_W(OFS_W), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI), .BM_W(BM_W)
  ) u_cfg (
    .clk_i, .rst_ni, .mrst_i, .mode_i(mode), .use_rd_i(use_rd), .ofs_sel_i(ofs_sel),
    .bm_i(bm_cap), .wr_addr_i, .rd_addr_i, .first_i(first), .commit_i(commit),
    .queue_count_o, .depth_o, .ofs_o, .bus_mode_o
  );

  qss_chain_ctrl u_chain (
    .clk_i, .rst_ni, .mrst_i, .last_i(last), .serial_i(mode == MODE_SERIAL),
    .chain_in_i, .chain_out_o
  );

  p_frozen_after_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chain_out_o && !mrst_i) |=> ($stable(queue_count_o) && $stable(depth_o)
                                   && $stable(ofs_o) && $stable(bus_mode_o)));
endmodule

// File: tb/queue_setup_seq_bench.sv
module queue_setup_seq_bench;
  localparam int LOAD = 16, MAXQ = 64, LOGQ = 6, MEM = 16384, OFS_LO = 8, OFS_HI = 128;

  logic       clk = 1'b0, rst_n = 1'b0, mrst = 1'b0, dflt = 1'b0, ofs_sel = 1'b0, chain_in = 1'b0;
  logic [2:0] qsel = '0;
  logic [1:0] bm = '0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic       chain_out;
  logic [1:0] mode;
  logic [6:0] qc;
  logic [14:0] dp;
  logic [7:0] ofs;
  logic [1:0] bmode;

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  queue_setup_seq u_queue_setup_seq (
    .clk_i(clk), .rst_ni(rst_n), .mrst_i(mrst), .dflt_mode_i(dflt), .qsel_i(qsel),
    .ofs_sel_i(ofs_sel), .bm_i(bm), .wr_addr_i(wr_addr), .rd_addr_i(rd_addr),
    .chain_in_i(chain_in), .chain_out_o(chain_out), .mode_o(mode),
    .queue_count_o(qc), .depth_o(dp), .ofs_o(ofs), .bus_mode_o(bmode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle,1 load,2 wait,3 done,4 serial
  int m_ph, m_cnt, m_k, m_mode, e_qc, e_dp, e_ofs, e_bm, e_out;
  bit m_use_rd, m_ofsel, m_waited;
  int m_bm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_k = 0; m_mode = 0; m_use_rd = 0; m_ofsel = 0; m_bm = 0;
      e_qc = 0; e_dp = 0; e_ofs = 0; e_bm = 0; e_out = 1; m_waited = 0;
    end else if (mrst) begin
      m_mode   = !dflt ? 0 : ((qsel == 3'b110 || qsel == 3'b111) ? 2 : 1);
      m_use_rd = (qsel == 3'b111);
      m_ofsel  = ofs_sel;
      m_bm     = int'(bm);
      m_ph = 1; m_cnt = 0; m_waited = 0;
      e_qc = 0; e_dp = 0; e_ofs = 0; e_bm = 0; e_out = 1;
    end else begin
      case (m_ph)
        1: begin
          if (m_cnt == 0) m_k = m_use_rd ? int'(rd_addr[2:0]) : int'(wr_addr[2:0]);
          if (m_cnt == LOAD - 1) begin
            if (m_mode == 0) m_ph = 4;
            else begin
              int kk;
              kk = (m_mode == 2) ? ((m_k > LOGQ) ? LOGQ : m_k) : LOGQ;
              e_qc = 1 << kk; e_dp = MEM >> kk;
              e_ofs = m_ofsel ? OFS_HI : OFS_LO; e_bm = m_bm;
              if (!chain_in) begin m_ph = 3; e_out = 0; end
              else begin m_ph = 2; m_waited = 1; end
            end
          end
          m_cnt++;
        end
        2: if (!chain_in) begin m_ph = 3; e_out = 0; end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(m_waited ? "R9 chain_out" : "R8 chain_out", int'(chain_out), e_out);
      chk("R2 mode", int'(mode), m_mode);
      chk(m_mode == 0 ? "R11 count" : (e_qc == 0 ? "R3 count" : (m_mode == 2 ? "R5 count" : "R4 count")),
          int'(qc), e_qc);
      chk(m_mode == 0 ? "R11 depth" : (m_mode == 2 ? "R5 depth" : "R4 depth"), int'(dp), e_dp);
      chk("R6 offset", int'(ofs), e_ofs);
      chk("R7 bus_mode", int'(bmode), e_bm);
    end
  end

  task automatic setup(input logic d, input logic [2:0] q, input logic o, input logic [1:0] b,
                       input logic [7:0] wa, input logic [7:0] ra);
    @(negedge clk);
    dflt = d; qsel = q; ofs_sel = o; bm = b; wr_addr = wa; rd_addr = ra; mrst = 1'b1;
    @(negedge clk);
    chk("R1 high in mrst", int'(chain_out), 1);
    chk("R1 cleared in mrst", int'(qc), 0);
    repeat (2) @(negedge clk);
    mrst = 1'b0;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out", int'(chain_out), 1);
    chk("R1 reset count", int'(qc), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // default mode, upstream already done
    chain_in = 1'b0;
    setup(1'b1, 3'b000, 1'b0, 2'd0, 8'h00, 8'h00);
    repeat (LOAD - 1) @(negedge clk);
    chk("R3 before commit", int'(qc), 0);
    chk("R3 out before commit", int'(chain_out), 1);
    @(negedge clk);
    chk("R3 commit count", int'(qc), MAXQ);
    chk("R4 depth", int'(dp), MEM / MAXQ);
    chk("R8 out falls", int'(chain_out), 0);
    repeat (4) @(negedge clk);

    // parallel via write address, k=3; address changed after first edge
    setup(1'b1, 3'b110, 1'b0, 2'd1, 8'hA3, 8'h05);
    @(negedge clk);
    wr_addr = 8'h01;
    repeat (LOAD - 1) @(negedge clk);
    chk("R2 parallel mode", int'(mode), 2);
    chk("R5 wr count", int'(qc), 8);
    chk("R5 wr depth", int'(dp), MEM / 8);
    chk("R7 bm", int'(bmode), 1);
    repeat (3) @(negedge clk);

    // parallel via read address, k=7 clamps; upstream still busy
    chain_in = 1'b1;
    setup(1'b1, 3'b111, 1'b1, 2'd2, 8'h01, 8'h07);
    repeat (LOAD) @(negedge clk);
    chk("R5 clamp count", int'(qc), MAXQ);
    chk("R6 offset high", int'(ofs), OFS_HI);
    chk("R7 bm", int'(bmode), 2);
    chk("R9 held", int'(chain_out), 1);
    repeat (5) @(negedge clk);
    chk("R9 still held", int'(chain_out), 1);
    chain_in = 1'b0;
    @(negedge clk);
    chk("R9 released", int'(chain_out), 0);

    // after done: everything ignored
    for (int i = 0; i < 10; i++) begin
      chain_in = i[0]; dflt = i[1]; qsel = 3'(i); ofs_sel = ~i[0];
      bm = 2'(i); wr_addr = 8'(i * 7); rd_addr = 8'(i * 3);
      @(negedge clk);
    end
    chk("R10 count frozen", int'(qc), MAXQ);
    chk("R10 offset frozen", int'(ofs), OFS_HI);
    chk("R10 out frozen", int'(chain_out), 0);

    // non-parallel code with default pin high gives default mode
    chain_in = 1'b0;
    setup(1'b1, 3'b101, 1'b0, 2'd3, 8'h02, 8'h02);
    repeat (LOAD) @(negedge clk);
    chk("R2 default mode", int'(mode), 1);
    chk("R4 count", int'(qc), MAXQ);
    chk("R6 offset low", int'(ofs), OFS_LO);

    // serial mode: never completes
    setup(1'b0, 3'b110, 1'b1, 2'd1, 8'h03, 8'h03);
    repeat (LOAD + 20) @(negedge clk);
    chk("R11 mode", int'(mode), 0);
    chk("R11 count", int'(qc), 0);
    chk("R11 out high", int'(chain_out), 1);

    cmp_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule